// File: doc/BRIEF.md
# Programmable I/O Pin Controller

This block is the control logic behind one user I/O pin on the perimeter of a cell array. An exit cell on the array edge supplies the data to be driven onto the pin. An entrance cell next to it receives whatever level the pin carries. Between them sits a small set of configuration bits. These bits choose where the output-enable comes from, whether a logic 1 is driven or only released (open-collector style), whether a weak pull-up holds an idle pin high, and whether the perimeter cells register the outgoing or incoming data on the column clock.

The pin itself is modelled as three things: the data the block drives, the enable for that driver, and the resolved level seen on the wire. An external driver can also act on the pin, through `ext_oe` and `ext_val`. The resolved level comes from the block's own driver, the external driver and the pull-up together. If the level cannot be decided, the block raises a flag, and in a four-state simulator the level itself is X. The slew-rate and input-threshold bits are analog settings. The block only stores them and shows them on output ports.

A parameter fixes the pin as one of two kinds. The two kinds alternate around the array, and they differ only in which of the two edge-facing cell signals they use.

Top module: `iopin_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first configuration write, the pin does not drive (`pad_oe`=0) and the pull-up is on. With no external driver, the pin therefore reads 1 and `pin_unknown` is 0.
- R2: Enable source code 2'b00 in `cfg_word[1:0]` makes the pin drive at all times, unless R6 releases it.
- R3: Code 2'b10 takes an active-low enable from `bus_vert`. The pin drives when `bus_vert` is 0, and `bus_horz` has no effect.
- R4: Code 2'b11 takes an active-low enable from `bus_horz`. The pin drives when `bus_horz` is 0, and `bus_vert` has no effect.
- R5: Code 2'b01 never drives the pin, whatever the two buses carry.
- R6: With open-collector mode on (`cfg_word[2]`=1), an outgoing 1 is released (`pad_oe`=0). An outgoing 0 is driven when the enable source allows it.
- R7: With the pull-up on (`cfg_word[3]`=1), a pin that nobody drives reads 1 and `pin_unknown` stays 0.
- R8: `pin_unknown` is 1 in two cases: when nobody drives the pin and the pull-up is off, and when both drivers act on the pin with different values. In every other case it is 0.
- R9: With the output register on (`cfg_word[4]`=1), `pad_out` follows the selected exit signal one column-clock edge later. With it off, `pad_out` follows the exit signal in the same cycle.
- R10: With the input register on (`cfg_word[5]`=1), the entrance signal follows the pin level one clock edge later. With it off, the entrance signal follows the pin level in the same cycle.
- R11: A kind-A pin (`PIN_KIND`=0) drives from `exit_a` and delivers the pin to `ent_a`, holding `ent_b` at 0. A kind-B pin (`PIN_KIND`=1) uses `exit_b` and `ent_b`, holding `ent_a` at 0.
- R12: `cfg_word[6]` and `cfg_word[7]` are stored and shown on `slew_fast` and `thresh_cmos`. Both are 0 after reset.
- R13: A configuration word takes effect on the rising `clk` edge at which `cfg_we` is 1. The enable and drive paths then respond in the same cycle as their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock for the configuration and perimeter registers |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cfg_we | input | 1 | Loads `cfg_word` at the next rising edge |
| cfg_word | input | 8 | Configuration word (fields as in R2 to R12) |
| exit_a | input | 1 | Edge-facing A signal of the exit cell |
| exit_b | input | 1 | Edge-facing B signal of the exit cell |
| bus_vert | input | 1 | Vertical local bus of the output cell (active-low enable) |
| bus_horz | input | 1 | Horizontal local bus of the output cell (active-low enable) |
| ext_oe | input | 1 | An external driver is acting on the pin |
| ext_val | input | 1 | Value of the external driver |
| pad_out | output | 1 | Data presented to the pin driver |
| pad_oe | output | 1 | Pin driver enable |
| pin_level | output | 1 | Resolved pin level (X when undecidable) |
| pin_unknown | output | 1 | Pin level cannot be decided |
| ent_a | output | 1 | Edge-facing A input of the entrance cell |
| ent_b | output | 1 | Edge-facing B input of the entrance cell |
| slew_fast | output | 1 | Stored slew-rate selection |
| thresh_cmos | output | 1 | Stored input-threshold selection |

## Verification
A wrong enable source shows on `pad_oe` in the same cycle that the selected bus changes, so a decode fault is visible within one clock of the stimulus. A configuration word loaded into the wrong fields shows at the ports right after the write edge: the pin drives when it should stay quiet, it reads X instead of 1, or the stored analog bits come out wrong. A register that has been bypassed or left stuck moves `pad_out` or the entrance signal one edge early or one edge late, and the cycle-exact samples catch that.

// File: rtl/iopin_pkg.sv
`timescale 1ns/1ps
package iopin_pkg;

  typedef enum logic [1:0] {
    OE_ALWAYS = 2'b00,
    OE_NEVER  = 2'b01,
    OE_VBUS   = 2'b10,
    OE_HBUS   = 2'b11
  } oe_src_e;

  // packed from MSB: word bit 7 down to bits 1:0
  typedef struct packed {
    logic    thresh_cmos;
    logic    slew_fast;
    logic    in_reg;
    logic    out_reg;
    logic    pull_up;
    logic    open_drain;
    oe_src_e oe_src;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  localparam pin_cfg_t CFG_POWERUP = '{
    thresh_cmos: 1'b0,
    slew_fast:   1'b0,
    in_reg:      1'b0,
    out_reg:     1'b0,
    pull_up:     1'b1,
    open_drain:  1'b0,
    oe_src:      OE_NEVER
  };

  // active-low enable control chosen by the source code
  function automatic logic oe_control(oe_src_e src, logic vbus, logic hbus);
    case (src)
      OE_ALWAYS: oe_control = 1'b0;
      OE_NEVER:  oe_control = 1'b1;
      OE_VBUS:   oe_control = vbus;
      default:   oe_control = hbus;
    endcase
  endfunction

  // driver is on when the control is low and open-collector does not release
  function automatic logic drive_on(logic ctl, logic od, logic data);
    drive_on = !ctl && !(od && data);
  endfunction

  function automatic logic level_undecided(logic own_oe, logic own_val,
                                           logic ext_oe, logic ext_val,
                                           logic pull);
    if (own_oe && ext_oe)       level_undecided = (own_val != ext_val);
    else if (own_oe || ext_oe)  level_undecided = 1'b0;
    else                        level_undecided = !pull;
  endfunction

  function automatic logic level_value(logic own_oe, logic own_val,
                                       logic ext_oe, logic ext_val,
                                       logic pull);
    if (level_undecided(own_oe, own_val, ext_oe, ext_val, pull))
      level_value = 1'bx;
    else if (own_oe)
      level_value = own_val;
    else if (ext_oe)
      level_value = ext_val;
    else
      level_value = 1'b1;
  endfunction

endpackage

// File: rtl/iopin_cfg.sv
`timescale 1ns/1ps
module iopin_cfg
  import iopin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] word,
  output pin_cfg_t         cfg
);

  pin_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= CFG_POWERUP;
    else if (we) cfg_q <= pin_cfg_t'(word);
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/iopin_outpath.sv
`timescale 1ns/1ps
module iopin_outpath
  import iopin_pkg::*;
#(
  parameter int PIN_KIND = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pin_cfg_t cfg,
  input  logic     exit_a,
  input  logic     exit_b,
  input  logic     bus_vert,
  input  logic     bus_horz,
  output logic     data_sel,
  output logic     oe_ctl,
  output logic     pad_out,
  output logic     pad_oe
);

  logic out_q;

  generate
    if (PIN_KIND == 0) begin : g_kind_a
      assign data_sel = exit_a | (exit_b & 1'b0);
    end else begin : g_kind_b
      assign data_sel = exit_b | (exit_a & 1'b0);
    end
  endgenerate

  // perimeter register always samples; the config bit picks the path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= data_sel;
  end

  always_comb begin
    pad_out = cfg.out_reg ? out_q : data_sel;
    oe_ctl  = oe_control(cfg.oe_src, bus_vert, bus_horz);
    pad_oe  = drive_on(oe_ctl, cfg.open_drain, pad_out);
  end

endmodule

// File: rtl/iopin_inpath.sv
`timescale 1ns/1ps
module iopin_inpath
  import iopin_pkg::*;
#(
  parameter int PIN_KIND = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pin_cfg_t cfg,
  input  logic     pad_out,
  input  logic     pad_oe,
  input  logic     ext_oe,
  input  logic     ext_val,
  output logic     pin_level,
  output logic     pin_unknown,
  output logic     ent_a,
  output logic     ent_b
);

  logic in_q;
  logic ent_dat;

  always_comb begin
    pin_unknown = level_undecided(pad_oe, pad_out, ext_oe, ext_val, cfg.pull_up);
    pin_level   = level_value(pad_oe, pad_out, ext_oe, ext_val, cfg.pull_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= 1'b0;
    else        in_q <= pin_level;
  end

  assign ent_dat = cfg.in_reg ? in_q : pin_level;

  generate
    if (PIN_KIND == 0) begin : g_kind_a
      assign ent_a = ent_dat;
      assign ent_b = 1'b0;
    end else begin : g_kind_b
      assign ent_a = 1'b0;
      assign ent_b = ent_dat;
    end
  endgenerate

endmodule

// File: rtl/iopin_ctrl.sv
`timescale 1ns/1ps
module iopin_ctrl
  import iopin_pkg::*;
#(
  parameter int PIN_KIND = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_word,
  input  logic       exit_a,
  input  logic       exit_b,
  input  logic       bus_vert,
  input  logic       bus_horz,
  input  logic       ext_oe,
  input  logic       ext_val,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       pin_level,
  output logic       pin_unknown,
  output logic       ent_a,
  output logic       ent_b,
  output logic       slew_fast,
  output logic       thresh_cmos
);

  pin_cfg_t cfg_q;
  logic     exit_sel;
  logic     oe_ctl;

  iopin_cfg u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .word (cfg_word),
    .cfg  (cfg_q)
  );

  iopin_outpath #(.PIN_KIND(PIN_KIND)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg_q),
    .exit_a  (exit_a),
    .exit_b  (exit_b),
    .bus_vert(bus_vert),
    .bus_horz(bus_horz),
    .data_sel(exit_sel),
    .oe_ctl  (oe_ctl),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  iopin_inpath #(.PIN_KIND(PIN_KIND)) u_in (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg_q),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .ext_oe     (ext_oe),
    .ext_val    (ext_val),
    .pin_level  (pin_level),
    .pin_unknown(pin_unknown),
    .ent_a      (ent_a),
    .ent_b      (ent_b)
  );

  assign slew_fast   = cfg_q.slew_fast;
  assign thresh_cmos = cfg_q.thresh_cmos;

endmodule

// File: rtl/iopin_ctrl_chk.sv
`timescale 1ns/1ps
module iopin_ctrl_chk
  import iopin_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input pin_cfg_t cfg_q,
  input logic     exit_sel,
  input logic     oe_ctl,
  input logic     pad_out,
  input logic     pad_oe,
  input logic     ext_oe,
  input logic     pin_level,
  input logic     pin_unknown
);

  // R1
  powerup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pad_oe && cfg_q.pull_up));

  // R5
  never_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.oe_src == OE_NEVER) |-> !pad_oe);

  // R2
  always_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.oe_src == OE_ALWAYS && !cfg_q.open_drain) |-> pad_oe);

  // R6
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.open_drain && pad_out) |-> !pad_oe);

  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> !oe_ctl);

  // R9
  out_reg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.out_reg && $past(rst_n)) |-> (pad_out == $past(exit_sel)));

  // R7
  pull_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pad_oe && !ext_oe && cfg_q.pull_up) |-> (pin_level && !pin_unknown));

  // R8
  float_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pad_oe && !ext_oe && !cfg_q.pull_up) |-> pin_unknown);

endmodule

bind iopin_ctrl iopin_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_q      (cfg_q),
  .exit_sel   (exit_sel),
  .oe_ctl     (oe_ctl),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .ext_oe     (ext_oe),
  .pin_level  (pin_level),
  .pin_unknown(pin_unknown)
);

// File: tb/test_iopin_ctrl.sv
`timescale 1ns/1ps
module test_iopin_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_word = 8'h00;
  logic       exit_a = 1'b0, exit_b = 1'b0;
  logic       bus_vert = 1'b1, bus_horz = 1'b1;
  logic       ext_oe = 1'b0, ext_val = 1'b0;

  logic pad_out, pad_oe, pin_level, pin_unknown, ent_a, ent_b, slew_fast, thresh_cmos;
  logic b_pad_out, b_pad_oe, b_pin_level, b_pin_unknown, b_ent_a, b_ent_b, b_slew, b_thresh;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  iopin_ctrl #(.PIN_KIND(0)) i_iopin_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .exit_a(exit_a), .exit_b(exit_b), .bus_vert(bus_vert), .bus_horz(bus_horz),
    .ext_oe(ext_oe), .ext_val(ext_val), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_level(pin_level), .pin_unknown(pin_unknown), .ent_a(ent_a), .ent_b(ent_b),
    .slew_fast(slew_fast), .thresh_cmos(thresh_cmos)
  );

  iopin_ctrl #(.PIN_KIND(1)) i_iopin_ctrl_b (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .exit_a(exit_a), .exit_b(exit_b), .bus_vert(bus_vert), .bus_horz(bus_horz),
    .ext_oe(ext_oe), .ext_val(ext_val), .pad_out(b_pad_out), .pad_oe(b_pad_oe),
    .pin_level(b_pin_level), .pin_unknown(b_pin_unknown), .ent_a(b_ent_a), .ent_b(b_ent_b),
    .slew_fast(b_slew), .thresh_cmos(b_thresh)
  );

  typedef enum int {S_OE, S_OUT, S_LVL, S_UNK, S_ENTA, S_ENTB, S_SLEW, S_THR,
                    S_B_OUT, S_B_ENTA, S_B_ENTB} sig_e;
  typedef struct {string req; sig_e sig; logic val;} exp_t;
  exp_t sb[$];

  function automatic logic observe(sig_e s);
    case (s)
      S_OE:     observe = pad_oe;
      S_OUT:    observe = pad_out;
      S_LVL:    observe = pin_level;
      S_UNK:    observe = pin_unknown;
      S_ENTA:   observe = ent_a;
      S_ENTB:   observe = ent_b;
      S_SLEW:   observe = slew_fast;
      S_THR:    observe = thresh_cmos;
      S_B_OUT:  observe = b_pad_out;
      S_B_ENTA: observe = b_ent_a;
      default:  observe = b_ent_b;
    endcase
  endfunction

  // bench-side reference for the enable (active-low control, open-collector release)
  function automatic logic ref_oe(logic [7:0] w, logic d, logic v, logic h);
    logic ctl;
    ctl = (w[1:0] == 2'b00) ? 1'b0 : (w[1:0] == 2'b01) ? 1'b1 :
          (w[1:0] == 2'b10) ? v : h;
    return (ctl == 1'b0) && !(w[2] && d);
  endfunction

  task automatic expect_sig(string req, sig_e s, logic v);
    exp_t e;
    e.req = req; e.sig = s; e.val = v;
    sb.push_back(e);
  endtask

  // monitor: compares queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        logic a;
        e = sb.pop_front();
        a = observe(e.sig);
        n_checks++;
        if (a !== e.val) begin
          n_fail++;
          $display("FAIL %s sig=%s actual=%b expected=%b", e.req, e.sig.name(), a, e.val);
        end
      end
    end
  end

  task automatic write_cfg(logic [7:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, still held
    expect_sig("R1", S_OE, 1'b0);
    expect_sig("R1", S_LVL, 1'b1);
    expect_sig("R1", S_UNK, 1'b0);
    expect_sig("R12", S_SLEW, 1'b0);
    expect_sig("R12", S_THR, 1'b0);
    step();
    rst_n = 1'b1;
    step(); step();
    expect_sig("R1", S_OE, 1'b0);
    expect_sig("R1", S_LVL, 1'b1);
    expect_sig("R1", S_ENTA, 1'b1);

    // R2 R13: always drive, push-pull, pull-up on
    write_cfg(8'h08);
    exit_a = 1'b1;
    expect_sig("R2", S_OE, ref_oe(8'h08, 1'b1, bus_vert, bus_horz));
    expect_sig("R2", S_OUT, 1'b1);
    expect_sig("R2", S_ENTA, 1'b1);
    step();
    exit_a = 1'b0;
    expect_sig("R2", S_LVL, 1'b0);
    expect_sig("R11", S_ENTB, 1'b0);

    // R5 R8: never drive, no pull-up -> floating
    write_cfg(8'h01);
    bus_vert = 1'b0; bus_horz = 1'b0;
    expect_sig("R5", S_OE, 1'b0);
    expect_sig("R8", S_UNK, 1'b1);
    step();
    ext_oe = 1'b1; ext_val = 1'b0;
    expect_sig("R8", S_UNK, 1'b0);
    expect_sig("R8", S_LVL, 1'b0);
    step();
    ext_oe = 1'b0;

    // R3: vertical bus
    write_cfg(8'h0A);
    bus_vert = 1'b0; bus_horz = 1'b1;
    expect_sig("R3", S_OE, ref_oe(8'h0A, exit_a, 1'b0, 1'b1));
    step();
    bus_vert = 1'b1; bus_horz = 1'b0;
    expect_sig("R3", S_OE, 1'b0);
    expect_sig("R3", S_LVL, 1'b1);

    // R4: horizontal bus
    write_cfg(8'h0B);
    bus_vert = 1'b1; bus_horz = 1'b0;
    expect_sig("R4", S_OE, 1'b1);
    step();
    bus_vert = 1'b0; bus_horz = 1'b1;
    expect_sig("R4", S_OE, 1'b0);
    expect_sig("R7", S_LVL, 1'b1);

    // R6 R7: open-collector with pull-up
    write_cfg(8'h0C);
    exit_a = 1'b0;
    expect_sig("R6", S_OE, 1'b1);
    expect_sig("R6", S_LVL, 1'b0);
    step();
    exit_a = 1'b1;
    expect_sig("R6", S_OE, 1'b0);
    expect_sig("R7", S_LVL, 1'b1);
    expect_sig("R7", S_UNK, 1'b0);
    // R8: open-collector release without pull-up
    write_cfg(8'h04);
    expect_sig("R8", S_UNK, 1'b1);

    // R8: contention
    write_cfg(8'h00);
    exit_a = 1'b0; ext_oe = 1'b1; ext_val = 1'b1;
    expect_sig("R8", S_UNK, 1'b1);
    step();
    ext_val = 1'b0;
    expect_sig("R8", S_UNK, 1'b0);
    step();
    ext_oe = 1'b0;

    // R12: stored analog selections
    write_cfg(8'hC8);
    expect_sig("R12", S_SLEW, 1'b1);
    expect_sig("R12", S_THR, 1'b1);

    // R9: output register
    write_cfg(8'h18);
    exit_a = 1'b0;
    step();
    exit_a = 1'b1;
    expect_sig("R9", S_OUT, 1'b0);
    step();
    expect_sig("R9", S_OUT, 1'b1);
    expect_sig("R9", S_LVL, 1'b1);

    // R10: input register, pin driven externally
    write_cfg(8'h29);
    ext_oe = 1'b1; ext_val = 1'b0;
    step();
    expect_sig("R10", S_ENTA, 1'b0);
    ext_val = 1'b1;
    expect_sig("R10", S_ENTA, 1'b0);
    step();
    expect_sig("R10", S_ENTA, 1'b1);
    step();
    ext_oe = 1'b0;

    // R11: pin kinds
    write_cfg(8'h08);
    exit_a = 1'b0; exit_b = 1'b1;
    expect_sig("R11", S_OUT, 1'b0);
    expect_sig("R11", S_B_OUT, 1'b1);
    expect_sig("R11", S_B_ENTB, 1'b1);
    expect_sig("R11", S_B_ENTA, 1'b0);
    step();
    exit_a = 1'b1; exit_b = 1'b0;
    expect_sig("R11", S_B_OUT, 1'b0);
    expect_sig("R11", S_B_ENTB, 1'b0);
    expect_sig("R11", S_ENTA, 1'b1);
    expect_sig("R11", S_ENTB, 1'b0);
    step(); step();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #800000;
    join_any
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule